// File: doc/BRIEF.md
# Three-phase sine reference generator

This block produces three signed sinusoidal samples, spaced a third of a cycle apart, for use as the modulating waves of a carrier-based PWM stage. A divider turns the fixed system clock into a sample-rate enable. On each enable, a 32-bit phase accumulator advances by a programmable frequency word. The fundamental can therefore be retuned while the block runs. With the default 10 MHz clock and a divide ratio of 100, the sample rate is 100 kHz. The frequency resolution is then about 23 µHz, and a target of 0.1 Hz to 1.5 kHz needs words from about 4295 to 64424509.

All three phases come from the same accumulator. Phases B and C add fixed constants to the accumulator before the table is addressed, so the three phases cannot drift apart. The magnitude comes from a table that covers only half a cycle. The top accumulator bit picks the half, and in the second half the magnitude is negated. A fixed-point modulation index then scales each magnitude before the sign is applied. The results are registered and announced by a one-cycle valid strobe.

Top module: `tri_sine_ref`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and drives all three outputs to zero and `out_valid` low. This holds on the clock edge after reset is seen.
- R2: `out_valid` goes high for exactly one cycle in every DIV clock cycles. The first pulse is produced by the (DIV+2)-th rising edge after reset is released. The outputs change only on the edges that raise `out_valid`, and hold their value between pulses.
- R3: Sample k after reset (k = 0, 1, …) uses a phase equal to the sum, modulo 2^32, of the frequency words taken at the first k enables. The first sample after reset therefore has phase A at 0 degrees, and `ref_a` = 0.
- R4: `freq_word` is sampled only on the sample-enable edge. Changes between enables have no effect on any output.
- R5: The magnitude is looked up from bits [30:23] of a phase, used as an index i in 0..255. The table value is mag(i) = round(32767·sin(π·i/256)).
- R6: When bit 31 of a phase is 1, the output is the negated scaled magnitude. When bit 31 is 0, the output is the positive scaled magnitude.
- R7: Phase A uses the accumulator directly. Phase B uses accumulator + 0xAAAAAAAB, so it lags A by 120 degrees. Phase C uses accumulator + 0x55555555, so it lags A by 240 degrees. Both sums are taken modulo 2^32.
- R8: `amp` is an unsigned Q1.15 index in which 32768 means 1.0. The scaled magnitude is floor(mag·amp/32768). `amp` is taken on the edge that raises `out_valid`.
- R9: Any `amp` value above 32768 saturates to 32768.
- R10: No output ever takes the most negative 16-bit value, -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | ACC_W (32) | Phase step added at each sample enable |
| amp | input | AMP_W (16) | Modulation index, unsigned Q1.15 |
| out_valid | output | 1 | One-cycle strobe when new samples appear |
| ref_a | output | SAMP_W (16) | Phase A sample, signed |
| ref_b | output | SAMP_W (16) | Phase B sample, signed, lagging A by 120° |
| ref_c | output | SAMP_W (16) | Phase C sample, signed, lagging A by 240° |

## Verification
The hardest case to reach from the ports is a frequency word that changes between enables without being sampled. The stimulus handles this in three steps. It first freezes the phase with a zero word. It then lines up with the valid strobe, which shows where the next enable will fall. Finally, it fills every cycle between enables with changing junk words and restores zero just before the enable. The frozen outputs must then stay bit-for-bit unchanged. Saturation of the amplitude is checked on the same frozen phase, and a slow sweep with an index step of one visits all 512 signed table positions.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  localparam real TSR_PI = 3.14159265358979323846;

  // Rounded half-wave sine magnitude for table entry idx of 2**aw entries.
  function automatic int sine_mag(input int idx, input int aw, input int maxv);
    real x;
    x = real'(maxv) * $sin(TSR_PI * real'(idx) / real'(2 ** aw));
    return $rtoi(x + 0.5);
  endfunction

endpackage

// File: rtl/tsr_tick_div.sv
module tsr_tick_div #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/tsr_phase_acc.sv
module tsr_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc
);
  // The step is taken only on the enable edge, so a word that changes
  // between enables can never produce a partial or glitched step.
  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (tick) acc <= acc + step;
  end
endmodule

// File: rtl/tsr_half_rom.sv
module tsr_half_rom #(
  parameter int AW = 8,
  parameter int MW = 15
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [MW-1:0] q
);
  localparam int DEPTH = 2 ** AW;
  localparam int MAXV  = (2 ** MW) - 1;

  logic [MW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = MW'(tsr_pkg::sine_mag(i, AW, MAXV));
    end
  end

  // Registered read with an enable, so the table can map to block RAM.
  always_ff @(posedge clk) begin
    if (en) q <= mem[addr];
  end
endmodule

// File: rtl/tsr_scale_sign.sv
module tsr_scale_sign #(
  parameter int MW    = 15,
  parameter int AMP_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                neg,
  input  logic [MW-1:0]       mag,
  input  logic [AMP_W-1:0]    amp,
  output logic signed [MW:0]  out
);
  localparam int PW = MW + AMP_W;
  localparam logic [AMP_W-1:0] ONE = AMP_W'(1) << (AMP_W - 1);

  logic [AMP_W-1:0]  amp_c;
  logic [PW-1:0]     prod;
  logic [MW-1:0]     scaled;
  logic signed [MW:0] pos;
  logic              unused_prod;

  assign amp_c  = (amp > ONE) ? ONE : amp;
  assign prod   = PW'(mag) * PW'(amp_c);
  assign scaled = prod[AMP_W-1 +: MW];
  assign pos    = signed'({1'b0, scaled});
  assign unused_prod = ^{prod[AMP_W-2:0], prod[PW-1]};

  always_ff @(posedge clk) begin
    if (rst)       out <= '0;
    else if (load) out <= neg ? -pos : pos;
  end
endmodule

// File: rtl/tri_sine_ref.sv
module tri_sine_ref #(
  parameter int ACC_W  = 32,
  parameter int TBL_AW = 8,
  parameter int SAMP_W = 16,
  parameter int AMP_W  = 16,
  parameter int DIV    = 100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ACC_W-1:0]         freq_word,
  input  logic [AMP_W-1:0]         amp,
  output logic                     out_valid,
  output logic signed [SAMP_W-1:0] ref_a,
  output logic signed [SAMP_W-1:0] ref_b,
  output logic signed [SAMP_W-1:0] ref_c
);
  localparam int MAG_W = SAMP_W - 1;
  localparam int NPH   = 3;
  localparam longint unsigned FULL = 64'd1 << ACC_W;
  localparam logic [ACC_W-1:0] LAG120 = ACC_W'((2 * FULL + 1) / 3);
  localparam logic [ACC_W-1:0] LAG240 = ACC_W'((FULL + 1) / 3);

  logic             tick_w;
  logic [ACC_W-1:0] acc_w;
  logic             v1_q;
  logic signed [SAMP_W-1:0] ph_out [NPH];

  tsr_tick_div #(.DIV(DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(tick_w)
  );

  tsr_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk (clk),
    .rst (rst),
    .tick(tick_w),
    .step(freq_word),
    .acc (acc_w)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    localparam logic [ACC_W-1:0] OFS = (g == 0) ? '0 : ((g == 1) ? LAG120 : LAG240);

    logic [ACC_W-1:0] ph;
    logic [MAG_W-1:0] mag;
    logic             neg_q;
    logic             unused_lo;

    assign ph        = acc_w + OFS;
    assign unused_lo = ^ph[ACC_W-TBL_AW-2:0];

    tsr_half_rom #(.AW(TBL_AW), .MW(MAG_W)) u_rom (
      .clk (clk),
      .en  (tick_w),
      .addr(ph[ACC_W-2 -: TBL_AW]),
      .q   (mag)
    );

    always_ff @(posedge clk) begin
      if (rst)         neg_q <= 1'b0;
      else if (tick_w) neg_q <= ph[ACC_W-1];
    end

    tsr_scale_sign #(.MW(MAG_W), .AMP_W(AMP_W)) u_scale (
      .clk (clk),
      .rst (rst),
      .load(v1_q),
      .neg (neg_q),
      .mag (mag),
      .amp (amp),
      .out (ph_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1_q      <= tick_w;
      out_valid <= v1_q;
    end
  end

  assign ref_a = ph_out[0];
  assign ref_b = ph_out[1];
  assign ref_c = ph_out[2];
endmodule

// File: rtl/tri_sine_ref_chk.sv
module tri_sine_ref_chk #(
  parameter int ACC_W  = 32,
  parameter int AMP_W  = 16,
  parameter int SAMP_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [ACC_W-1:0]         freq_word,
  input logic [AMP_W-1:0]         amp,
  input logic                     out_valid,
  input logic signed [SAMP_W-1:0] ref_a,
  input logic signed [SAMP_W-1:0] ref_b,
  input logic signed [SAMP_W-1:0] ref_c,
  input logic                     tick,
  input logic [ACC_W-1:0]         acc
);
  localparam logic signed [SAMP_W-1:0] MOST_NEG = {1'b1, {(SAMP_W-1){1'b0}}};

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && ref_a == 0 && ref_b == 0 && ref_c == 0 && acc == 0));

  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> ($stable(ref_a) && $stable(ref_b) && $stable(ref_c)));

  // R3
  acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(acc));

  // R4
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (acc == $past(acc) + $past(freq_word)));

  // R8
  zero_amp_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(amp) == 0) |-> (ref_a == 0 && ref_b == 0 && ref_c == 0));

  // R10
  no_most_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_a != MOST_NEG && ref_b != MOST_NEG && ref_c != MOST_NEG));
endmodule

bind tri_sine_ref tri_sine_ref_chk #(
  .ACC_W (ACC_W),
  .AMP_W (AMP_W),
  .SAMP_W(SAMP_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .freq_word(freq_word),
  .amp      (amp),
  .out_valid(out_valid),
  .ref_a    (ref_a),
  .ref_b    (ref_b),
  .ref_c    (ref_c),
  .tick     (tick_w),
  .acc      (acc_w)
);

// File: tb/test_tri_sine_ref.sv
`timescale 1ns/1ps
module test_tri_sine_ref;
  localparam int DIV_T = 6;
  localparam real PI_T = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] freq_word = '0;
  logic [15:0] amp = 16'd32768;
  logic        out_valid;
  logic signed [15:0] ref_a, ref_b, ref_c;

  int n_cmp = 0;
  int n_bad = 0;
  string cur = "R1";

  always #2 clk = ~clk;

  tri_sine_ref #(.DIV(DIV_T)) i_tri_sine_ref (
    .clk(clk), .rst(rst), .freq_word(freq_word), .amp(amp),
    .out_valid(out_valid), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c)
  );

  // Expected sample from the requirements (R5, R6, R8, R9).
  function automatic int ref_val(input logic [31:0] p, input int a);
    int idx, mag, ac, s;
    idx = int'(p[30:23]);
    mag = $rtoi(32767.0 * $sin(PI_T * real'(idx) / 256.0) + 0.5);
    ac  = (a > 32768) ? 32768 : a;
    s   = (mag * ac) >>> 15;
    return p[31] ? -s : s;
  endfunction

  // Behavioural timing model
  int          cnt_m = 0;
  bit          tick_m = 0, v1_m = 0, exp_valid = 0;
  logic [31:0] acc_m = '0;
  logic [31:0] pend[$];
  int          exp_a = 0, exp_b = 0, exp_c = 0;

  always @(posedge clk) begin
    logic [31:0] p;
    if (rst) begin
      cnt_m = 0; tick_m = 0; v1_m = 0; acc_m = '0; pend.delete();
      exp_valid = 0; exp_a = 0; exp_b = 0; exp_c = 0;
    end else begin
      exp_valid = v1_m;
      if (v1_m && pend.size() > 0) begin
        p = pend.pop_front();
        exp_a = ref_val(p, int'(amp));
        exp_b = ref_val(p + 32'hAAAAAAAB, int'(amp));
        exp_c = ref_val(p + 32'h55555555, int'(amp));
      end
      v1_m = tick_m;
      if (tick_m) begin
        pend.push_back(acc_m);
        acc_m = acc_m + freq_word;
      end
      if (cnt_m == DIV_T - 1) begin cnt_m = 0; tick_m = 1; end
      else begin cnt_m++; tick_m = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // Per-cycle comparison against the model (R2 R5 R6 R7 R8 R10 plus current tag)
  always @(negedge clk) begin
    check(out_valid == exp_valid, {"R2 valid ", cur}, int'(out_valid), int'(exp_valid));
    check(int'(ref_a) == exp_a, {"R5 R6 R8 ref_a ", cur}, int'(ref_a), exp_a);
    check(int'(ref_b) == exp_b, {"R7 ref_b ", cur}, int'(ref_b), exp_b);
    check(int'(ref_c) == exp_c, {"R7 ref_c ", cur}, int'(ref_c), exp_c);
    check(int'(ref_a) != -32768 && int'(ref_b) != -32768 && int'(ref_c) != -32768,
          "R10 most negative", int'(ref_a), -32767);
  end

  task automatic wait_valid();
    @(negedge clk);
    while (!out_valid) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    repeat (n * DIV_T) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int cyc, pulses, a0, b0, c0;
    logic [31:0] junk;
    repeat (3) @(negedge clk);
    check(ref_a == 0 && ref_b == 0 && ref_c == 0 && !out_valid, "R1 reset state", int'(ref_a), 0);

    // R3 / R2: first sample and its latency
    cur = "R3";
    freq_word = 32'h0080_0000;
    rst = 1'b0;
    cyc = 0;
    @(negedge clk); cyc++;
    while (!out_valid) begin @(negedge clk); cyc++; end
    check(cyc == DIV_T + 2, "R2 first pulse latency", cyc, DIV_T + 2);
    check(ref_a == 0, "R3 phase A starts at zero", int'(ref_a), 0);
    check(int'(ref_b) == ref_val(32'hAAAAAAAB, 32768), "R7 phase B start", int'(ref_b),
          ref_val(32'hAAAAAAAB, 32768));

    // R5 R6: slow sweep, index step 1, covers every signed table slot
    cur = "R5 R6 sweep";
    run_ticks(520);

    // R2: pulse count in a window
    pulses = 0;
    repeat (20 * DIV_T) begin @(negedge clk); if (out_valid) pulses++; end
    check(pulses == 20, "R2 pulse rate", pulses, 20);

    // R6 R3: wrap-around and half-cycle alternation
    cur = "R6 wrap";
    freq_word = 32'h8000_0000; run_ticks(10);
    freq_word = 32'hFFFF_FFFF; run_ticks(10);
    freq_word = 32'h0200_0000; run_ticks(100);

    // R8: fractional index and zero
    cur = "R8 scale";
    amp = 16'd21299; run_ticks(150);
    amp = 16'd0; run_ticks(5);
    wait_valid();
    check(ref_a == 0 && ref_b == 0 && ref_c == 0, "R8 zero amplitude", int'(ref_b), 0);

    // R9: saturation on a frozen phase
    cur = "R9 saturate";
    freq_word = 32'h1234_5678; run_ticks(3);
    freq_word = 32'h0; amp = 16'd32768; run_ticks(4);
    wait_valid();
    a0 = int'(ref_a); b0 = int'(ref_b); c0 = int'(ref_c);
    amp = 16'd65535; run_ticks(3);
    wait_valid();
    check(int'(ref_a) == a0 && int'(ref_b) == b0, "R9 amp 65535 saturates", int'(ref_a), a0);
    amp = 16'd32769; run_ticks(3);
    wait_valid();
    check(int'(ref_c) == c0, "R9 amp 32769 saturates", int'(ref_c), c0);

    // R4: junk frequency words between enables are ignored
    cur = "R4 ignore";
    junk = 32'h1357_9BDF;
    for (int k = 0; k < 5; k++) begin
      wait_valid();
      for (int j = 0; j < DIV_T - 2; j++) begin
        junk = junk * 32'd1103515245 + 32'd12345;
        freq_word = junk;
        @(negedge clk);
      end
      freq_word = 32'h0;
    end
    wait_valid();
    check(int'(ref_a) == a0 && int'(ref_b) == b0 && int'(ref_c) == c0,
          "R4 phase frozen", int'(ref_a), a0);

    // R1 R3: reset mid-run restarts phase A at zero
    cur = "R3 restart";
    freq_word = 32'h0400_0000;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(ref_a == 0 && !out_valid, "R1 mid-run reset", int'(ref_a), 0);
    rst = 1'b0;
    wait_valid();
    check(ref_a == 0, "R3 restart sample 0", int'(ref_a), 0);
    wait_valid();
    check(int'(ref_a) == ref_val(32'h0400_0000, 32768), "R3 restart sample 1",
          int'(ref_a), ref_val(32'h0400_0000, 32768));
    run_ticks(20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule